// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block is the receive front end of an asynchronous serial port. It takes one serial line, passes it through a synchroniser and finds the falling edge of a start bit. Using a 16x oversampling tick supplied from outside, it samples each following bit at its midpoint. It rebuilds a character of 5 to 8 data bits, least significant bit first, with an optional odd or even parity bit and one stop bit. For each character it gives a single-cycle valid strobe together with the data byte and three condition flags: framing, parity and break.

Two line conditions get special handling. If the stop bit reads low, the character is still delivered, with its framing flag set. The low stop bit is then taken as the start bit of the next character, and reception continues at once without waiting for a new falling edge. A character received this way may still be wrong even when it reports no error. If the whole frame is low, meaning the start bit, every data bit, the parity bit and the stop bit, the block reports a break instead. It then ignores the line until the line returns high.

The baud tick source, any receive queue and any register access sit outside this block. Data length and parity mode are captured when a start bit is first seen, and they hold for that character and for any character that follows it through resynchronisation.

Top module: `serial_rx`

## Requirements
- R1: After reset, `char_vld_o`, `char_data_o`, `frame_err_o`, `par_err_o` and `brk_o` are all 0, and no strobe occurs while the line stays high.
- R2: A falling edge on `rx_i` starts a character only if the line still reads 0 at the start bit's midpoint, which is 8 ticks after the edge is seen. A shorter low pulse produces no strobe.
- R3: `cfg_len_i` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. Data bits that are not received read 0 in `char_data_o`.
- R4: `cfg_par_i` selects the parity mode: 0 means none, 1 means odd, 2 means even and 3 means none. In odd mode `par_err_o` is 1 when the data bits plus the parity bit hold an even number of ones. In even mode it is 1 when they hold an odd number of ones. With no parity it is always 0.
- R5: Every character ends in exactly one `char_vld_o` pulse that lasts one clock. The data and flag outputs are valid during that pulse. A character whose stop bit is 1 has `frame_err_o` at 0.
- R6: A stop bit sampled at 0 sets `frame_err_o` in that character's strobe.
- R7: After a framing error that is not a break, the low stop bit serves as the next start bit. The bits that follow are received as a new character with no further falling edge.
- R8: A frame that is low in every bit position gives one strobe with `char_data_o` at 0x00, `brk_o` at 1, `frame_err_o` at 1 and `par_err_o` at 0.
- R9: After a break no new character is started while `rx_i` stays low, however long that lasts. Once the line returns high, the next frame is received normally.
- R10: An all-zero data field with a stop bit of 1, or with a parity bit of 1 and a stop bit of 0, is not a break, so `brk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line; idle is 1 |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len_i | input | 2 | Data length select (0..3 for 5..8 bits) |
| cfg_par_i | input | 2 | Parity mode (0 none, 1 odd, 2 even, 3 none) |
| char_vld_o | output | 1 | One-cycle character strobe |
| char_data_o | output | 8 | Received data, right-aligned |
| frame_err_o | output | 1 | Stop bit was 0 |
| par_err_o | output | 1 | Parity bit mismatch |
| brk_o | output | 1 | Whole frame was low |

## Verification
On the tick that samples a low stop bit, two things happen in the same cycle. The block delivers the bad character with its framing flag set, and it starts receiving the next character with the low stop bit as that character's start. The bench provokes this by sending a frame with a low stop bit and then, with no idle gap and no new start bit, the data bits of a second character. It expects two strobes: the first with `frame_err_o` set and the first data value, the second clean and carrying the second value. The same sampling cycle also has to separate a break from a plain framing error. Frames that are all zero except for a high parity bit or a high stop bit must never raise `brk_o`.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_BRKW  = 3'd5
    } rx_state_e;

    localparam logic [1:0] PAR_NONE = 2'd0;
    localparam logic [1:0] PAR_ODD  = 2'd1;
    localparam logic [1:0] PAR_EVEN = 2'd2;

    function automatic logic par_on(input logic [1:0] mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN);
    endfunction

    // index of the last data bit for a length code (5..8 bits)
    function automatic logic [2:0] last_idx(input logic [1:0] len);
        return 3'd4 + {1'b0, len};
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/serial_rx_parity.sv
module serial_rx_parity
    import serial_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    mode_i,
    input  logic          pbit_i,
    output logic          err_o
);
    logic ones_odd;

    always_comb begin
        ones_odd = (^data_i) ^ pbit_i;
        unique case (mode_i)
            PAR_ODD:  err_o = !ones_odd;
            PAR_EVEN: err_o = ones_odd;
            default:  err_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_s,
    input  logic          tick_i,
    input  logic [1:0]    cfg_len_i,
    input  logic [1:0]    cfg_par_i,
    output logic          vld_o,
    output logic [DW-1:0] data_o,
    output logic          ferr_o,
    output logic          perr_o,
    output logic          brk_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    idx;
        logic [DW-1:0] shf;
        logic          pbit;
        logic          allzero;
        logic [1:0]    len;
        logic [1:0]    par;
        logic          vld;
        logic [DW-1:0] dout;
        logic          ferr;
        logic          perr;
        logic          brk;
    } frm_t;

    frm_t n_d, n_q;
    logic par_mis;
    logic at_mid, at_full;

    serial_rx_parity #(.DW(DW)) u_par (
        .data_i (n_q.shf),
        .mode_i (n_q.par),
        .pbit_i (n_q.pbit),
        .err_o  (par_mis)
    );

    assign at_mid  = tick_i && (n_q.cnt == MID);
    assign at_full = tick_i && (n_q.cnt == LAST);

    always_comb begin
        n_d     = n_q;
        n_d.vld = 1'b0;
        unique case (n_q.st)
            ST_IDLE: begin
                if (tick_i && !rx_s) begin
                    n_d.st  = ST_START;
                    n_d.cnt = '0;
                    n_d.len = cfg_len_i;
                    n_d.par = cfg_par_i;
                end
            end
            ST_START: begin
                if (at_mid) begin
                    n_d.cnt = '0;
                    if (!rx_s) begin
                        n_d.st      = ST_DATA;
                        n_d.idx     = '0;
                        n_d.shf     = '0;
                        n_d.allzero = 1'b1;
                    end else begin
                        n_d.st = ST_IDLE;
                    end
                end else if (tick_i) begin
                    n_d.cnt = n_q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (at_full) begin
                    n_d.cnt          = '0;
                    n_d.shf[n_q.idx] = rx_s;
                    n_d.allzero      = n_q.allzero & !rx_s;
                    if (n_q.idx == last_idx(n_q.len)) begin
                        n_d.st = par_on(n_q.par) ? ST_PAR : ST_STOP;
                    end else begin
                        n_d.idx = n_q.idx + 1'b1;
                    end
                end else if (tick_i) begin
                    n_d.cnt = n_q.cnt + 1'b1;
                end
            end
            ST_PAR: begin
                if (at_full) begin
                    n_d.cnt     = '0;
                    n_d.pbit    = rx_s;
                    n_d.allzero = n_q.allzero & !rx_s;
                    n_d.st      = ST_STOP;
                end else if (tick_i) begin
                    n_d.cnt = n_q.cnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (at_full) begin
                    n_d.cnt  = '0;
                    n_d.vld  = 1'b1;
                    n_d.dout = n_q.shf;
                    n_d.perr = par_on(n_q.par) && par_mis;
                    n_d.ferr = !rx_s;
                    n_d.brk  = 1'b0;
                    if (rx_s) begin
                        n_d.st = ST_IDLE;
                    end else if (n_q.allzero) begin
                        n_d.brk  = 1'b1;
                        n_d.perr = 1'b0;
                        n_d.dout = '0;
                        n_d.st   = ST_BRKW;
                    end else begin
                        // low stop bit reused as a start bit already at its midpoint
                        n_d.st      = ST_DATA;
                        n_d.idx     = '0;
                        n_d.shf     = '0;
                        n_d.allzero = 1'b1;
                    end
                end else if (tick_i) begin
                    n_d.cnt = n_q.cnt + 1'b1;
                end
            end
            ST_BRKW: begin
                if (rx_s) n_d.st = ST_IDLE;
            end
            default: n_d.st = ST_IDLE;
        endcase
        if (n_q.st != ST_PAR && n_q.st != ST_STOP && n_d.st == ST_DATA && n_q.st == ST_START)
            n_d.pbit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q    <= '0;
            n_q.st <= ST_IDLE;
        end else begin
            n_q <= n_d;
        end
    end

    assign vld_o  = n_q.vld;
    assign data_o = n_q.dout;
    assign ferr_o = n_q.ferr;
    assign perr_o = n_q.perr;
    assign brk_o  = n_q.brk;

    // R2
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.st == ST_START && at_mid && rx_s) |=> (n_q.st == ST_IDLE));
    // R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        n_q.vld |=> !n_q.vld);
    // R4
    no_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.vld && !par_on(n_q.par)) |-> !n_q.perr);
    // R8
    break_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.vld && n_q.brk) |-> (n_q.ferr && !n_q.perr && n_q.dout == '0));
    // R9
    break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.st == ST_BRKW && !rx_s) |=> (n_q.st == ST_BRKW));
    // R7
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.st == ST_STOP && at_full && !rx_s && !n_q.allzero)
        |=> (n_q.st == ST_DATA && n_q.vld && n_q.ferr && !n_q.brk));
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    input  logic          tick_i,
    input  logic [1:0]    cfg_len_i,
    input  logic [1:0]    cfg_par_i,
    output logic          char_vld_o,
    output logic [DW-1:0] char_data_o,
    output logic          frame_err_o,
    output logic          par_err_o,
    output logic          brk_o
);
    logic rx_s;

    serial_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    serial_rx_framer #(.OSR(OSR), .DW(DW)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_s      (rx_s),
        .tick_i    (tick_i),
        .cfg_len_i (cfg_len_i),
        .cfg_par_i (cfg_par_i),
        .vld_o     (char_vld_o),
        .data_o    (char_data_o),
        .ferr_o    (frame_err_o),
        .perr_o    (par_err_o),
        .brk_o     (brk_o)
    );

    // R6
    frame_flag_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o && char_vld_o |-> frame_err_o);
endmodule

// File: tb/serial_rx_tb.sv
module serial_rx_tb;
    localparam int TDIV = 4;
    localparam int BITCLK = 16 * TDIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic vld, ferr, perr, brk;
    logic [7:0] dout;

    int n_chk = 0, n_fail = 0;
    int n_strb = 0;
    int dbl_strb = 0;
    logic prev_vld = 1'b0;
    logic [7:0] c_data;
    logic c_ferr, c_perr, c_brk;
    int tdiv_cnt = 0;

    always #5 clk = ~clk;

    serial_rx u_dut (
        .clk (clk), .rst_n (rst_n), .rx_i (rx), .tick_i (tick),
        .cfg_len_i (cfg_len), .cfg_par_i (cfg_par),
        .char_vld_o (vld), .char_data_o (dout), .frame_err_o (ferr),
        .par_err_o (perr), .brk_o (brk)
    );

    always @(negedge clk) begin
        tdiv_cnt = (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        tick = (tdiv_cnt == 0);
        if (vld) begin
            n_strb = n_strb + 1;
            c_data = dout; c_ferr = ferr; c_perr = perr; c_brk = brk;
        end
        if (vld && prev_vld) dbl_strb = dbl_strb + 1;
        prev_vld = vld;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic idle(input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(1'b1);
    endtask

    function automatic logic [7:0] lmask(input logic [1:0] len);
        return 8'hFF >> (3 - int'(len));
    endfunction

    // data bits only (LSB first), no start/stop
    task automatic send_data(input logic [1:0] len, input logic [7:0] d);
        for (int i = 0; i <= 4 + int'(len); i++) send_bit(d[i]);
    endtask

    task automatic send_frame(input logic [1:0] len, input logic [1:0] par,
                              input logic [7:0] d, input logic flip, input logic stopv);
        logic [7:0] m;
        logic pb;
        m = d & lmask(len);
        pb = (par == 2'd1) ? ~(^m) : (^m);
        cfg_len = len; cfg_par = par;
        send_bit(1'b0);
        send_data(len, m);
        if (par == 2'd1 || par == 2'd2) send_bit(pb ^ flip);
        send_bit(stopv);
    endtask

    // {len[12:11], par[10:9], flip[8], data[7:0]}
    localparam logic [12:0] VEC [8] = '{
        {2'd3, 2'd0, 1'b0, 8'hA5},
        {2'd0, 2'd0, 1'b0, 8'hFF},
        {2'd1, 2'd1, 1'b0, 8'h3C},
        {2'd2, 2'd2, 1'b0, 8'h7E},
        {2'd3, 2'd1, 1'b1, 8'h81},
        {2'd3, 2'd2, 1'b1, 8'h00},
        {2'd2, 2'd1, 1'b0, 8'h40},
        {2'd0, 2'd2, 1'b1, 8'h13}
    };

    initial begin : watchdog
        repeat (190000) @(negedge clk);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int base;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 vld", int'(vld), 0);
        chk("R1 flags", int'({ferr, perr, brk}), 0);
        chk("R1 data", int'(dout), 0);
        rst_n = 1'b1;
        idle(3);
        chk("R1 no strobe idle", n_strb, 0);

        // vector table: R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            logic [1:0] len, par;
            logic flip;
            logic [7:0] d;
            {len, par, flip, d} = VEC[v];
            base = n_strb;
            send_frame(len, par, d, flip, 1'b1);
            idle(1);
            chk("R5 one strobe", n_strb - base, 1);
            chk("R3 data", int'(c_data), int'(d & lmask(len)));
            chk("R4 parity flag", int'(c_perr), int'(flip && (par == 2'd1 || par == 2'd2)));
            chk("R5 no frame flag", int'(c_ferr), 0);
            chk("R10 no break", int'(c_brk), 0);
        end

        // R2 glitch rejected
        base = n_strb;
        rx = 1'b0; repeat (2 * TDIV) @(negedge clk);
        rx = 1'b1; idle(2);
        chk("R2 glitch no strobe", n_strb - base, 0);

        // R6 R7 framing error then resync without a new start
        base = n_strb;
        send_frame(2'd3, 2'd0, 8'h55, 1'b0, 1'b0);
        send_data(2'd3, 8'hA3);
        send_bit(1'b1);
        idle(1);
        chk("R7 two strobes", n_strb - base, 2);
        chk("R7 resync data", int'(c_data), 8'hA3);
        chk("R7 resync clean", int'({c_ferr, c_brk}), 0);

        base = n_strb;
        send_frame(2'd3, 2'd2, 8'h37, 1'b0, 1'b0);
        chk("R6 frame flag", int'(c_ferr), 1);
        chk("R6 data", int'(c_data), 8'h37);
        chk("R6 not break", int'(c_brk), 0);
        send_data(2'd3, 8'hFF); send_bit(1'b0); send_bit(1'b1); idle(2);

        // R10 zero data, parity bit 1, stop 0 -> framing only
        send_frame(2'd3, 2'd1, 8'h00, 1'b0, 1'b0);
        chk("R10 parity one not break", int'(c_brk), 0);
        chk("R10 frame flag", int'(c_ferr), 1);
        rx = 1'b1; idle(12);

        // R8 R9 break
        base = n_strb;
        cfg_len = 2'd3; cfg_par = 2'd0;
        for (int i = 0; i < 30; i++) send_bit(1'b0);
        chk("R8 one strobe", n_strb - base, 1);
        chk("R8 data", int'(c_data), 0);
        chk("R8 flags", int'({c_brk, c_ferr, c_perr}), 3'b110);
        idle(2);
        chk("R9 still one", n_strb - base, 1);
        send_frame(2'd3, 2'd0, 8'hC6, 1'b0, 1'b1);
        idle(1);
        chk("R9 recover data", int'(c_data), 8'hC6);
        chk("R9 recover clean", int'({c_brk, c_ferr}), 0);

        chk("R5 strobe one cycle", dbl_strb, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule